// File: doc/BRIEF.md
# Banked Binary Point Register Unit

This block holds the binary point setting of one processor's interrupt interface. The setting decides how an 8-bit interrupt priority splits into a group part, which governs preemption, and a sub-part, which only orders interrupts that are already pending. Two copies are kept. The main copy belongs to secure software. The alias copy belongs to non-secure software. Every register access carries a secure attribute, and that attribute selects the copy the access reaches. When the security feature is left out at build time, every access reaches the main copy.

A shared-point control input decides what non-secure software sees. When the control is clear, non-secure accesses read and write the alias copy. When it is set, non-secure software reads a value derived from the main copy, and its writes are dropped while the access still completes normally. The block also outputs the effective binary point and the preemption group priority. Both follow the group of the interrupt under consideration. Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `bpr_bank`

## Requirements
- R1: After reset the main copy holds 2 and the alias copy holds 3. A secure read returns 2, and a non-secure read with the shared-point control clear returns 3.
- R2: A secure write stores max(wdata[2:0], 2) into the main copy and leaves the alias copy unchanged. A secure read returns the main copy in the low 3 bits of rd_data_o, with the upper bits zero.
- R3: A non-secure write with the shared-point control clear stores max(wdata[2:0], 3) into the alias copy and leaves the main copy unchanged.
- R4: A non-secure write with the shared-point control set changes neither copy.
- R5: A non-secure read with the shared-point control set returns min(main + 1, 7).
- R6: A non-secure read with the shared-point control clear returns the alias copy.
- R7: The effective binary point is (alias − 1) for a group-1 interrupt while the shared-point control is clear. In every other case it is the main copy.
- R8: The group priority output equals the priority input with its low (effective binary point + 1) bits cleared.
- R9: When built without the security feature, all accesses read and write the main copy whatever their attribute, and the effective binary point is always the main copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| acc_secure_i | input | 1 | Access attribute: 1 = secure, 0 = non-secure |
| wr_data_i | input | DATA_W | Write data; only bits [2:0] are used |
| rd_data_o | output | DATA_W | Combinational read data for the current attribute |
| shared_bp_i | input | 1 | Shared-point control: non-secure view is derived from the main copy |
| irq_group1_i | input | 1 | Group of the interrupt being graded: 1 = group 1 |
| prio_i | input | PRIO_W | Priority of the interrupt being graded |
| eff_bp_o | output | 3 | Effective binary point for preemption |
| grp_prio_o | output | PRIO_W | Preemption group priority |

## Verification
Write data is swept over all 16 low-nibble patterns for each access path. Values below each floor show the separate clamps of the two copies. Values 6 and 7 show where the derived non-secure view saturates. After every secure write, the bench reads the alias copy back, and after every non-secure write it reads the main copy back, so leakage between the copies shows up at once. The grading outputs are swept over every priority value, for both groups and both control settings, using main/alias pairs chosen so that alias − 1 differs from main. This tells the alias path apart from the main path and exposes off-by-one errors in the mask. A second instance built without the security feature shows that the attribute and the control then have no effect.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
  localparam int BP_W = 3;
  typedef logic [BP_W-1:0] bp_t;

  function automatic bp_t bp_floor(input bp_t v, input bp_t lo);
    return (v < lo) ? lo : v;
  endfunction

  function automatic bp_t bp_inc_sat(input bp_t v);
    return (v == bp_t'(7)) ? bp_t'(7) : bp_t'(v + bp_t'(1));
  endfunction
endpackage

// File: rtl/bpr_store.sv
module bpr_store
  import bpr_pkg::*;
#(
  parameter int MIN_BP = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  bp_t  wr_val_i,
  output bp_t  val_o
);
  localparam bp_t FLOOR = bp_t'(MIN_BP);

  bp_t val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      val_q <= FLOOR;
    else if (wr_en_i) val_q <= bp_floor(wr_val_i, FLOOR);
  end

  assign val_o = val_q;

  AST_HOLD_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(val_o)); // R4
  AST_ABOVE_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_o >= FLOOR); // R2
endmodule

// File: rtl/bpr_view.sv
module bpr_view
  import bpr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MAIN_MIN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ns_acc_i,
  input  logic              shared_bp_i,
  input  bp_t               main_i,
  input  bp_t               alias_i,
  output logic [DATA_W-1:0] rd_data_o
);
  bp_t view;

  always_comb begin
    if (!ns_acc_i)        view = main_i;
    else if (shared_bp_i) view = bp_inc_sat(main_i);
    else                  view = alias_i;
  end

  assign rd_data_o = {{(DATA_W-BP_W){1'b0}}, view};

  AST_SHARED_VIEW_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_acc_i && shared_bp_i) |-> (rd_data_o > DATA_W'(MAIN_MIN))); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o >> BP_W) == '0); // R2
endmodule

// File: rtl/bpr_preempt.sv
module bpr_preempt
  import bpr_pkg::*;
#(
  parameter int PRIO_W   = 8,
  parameter int LOW_BP   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              use_alias_i,
  input  bp_t               main_i,
  input  bp_t               alias_i,
  input  logic [PRIO_W-1:0] prio_i,
  output bp_t               eff_bp_o,
  output logic [PRIO_W-1:0] grp_prio_o
);
  assign eff_bp_o = use_alias_i ? bp_t'(alias_i - bp_t'(1)) : main_i;

  // bit i survives only when it lies above the sub-priority field
  for (genvar i = 0; i < PRIO_W; i++) begin : g_mask
    assign grp_prio_o[i] = prio_i[i] & (i > int'(eff_bp_o));
  end

  AST_GRP_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_prio_o & ~prio_i) == '0); // R8
  AST_LOW_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_prio_o[LOW_BP:0] == '0); // R8
  AST_EFF_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_bp_o >= bp_t'(LOW_BP)); // R7
endmodule

// File: rtl/bpr_bank.sv
module bpr_bank
  import bpr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PRIO_W    = 8,
  parameter bit SEC_EXT   = 1'b1,
  parameter int MAIN_MIN  = 2,
  parameter int ALIAS_MIN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              acc_secure_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              shared_bp_i,
  input  logic              irq_group1_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic [2:0]        eff_bp_o,
  output logic [PRIO_W-1:0] grp_prio_o
);
  localparam int NCOPY  = 2;
  localparam int LOW_BP = (SEC_EXT && (ALIAS_MIN - 1 < MAIN_MIN)) ? ALIAS_MIN - 1 : MAIN_MIN;

  logic ns_acc;
  bp_t  wr_val;
  logic [NCOPY-1:0] copy_wr;
  bp_t  copy_val [NCOPY];

  assign ns_acc     = SEC_EXT && !acc_secure_i;
  assign wr_val     = bp_t'(wr_data_i[BP_W-1:0]);
  assign copy_wr[0] = wr_en_i && !ns_acc;
  assign copy_wr[1] = wr_en_i && ns_acc && !shared_bp_i;

  for (genvar g = 0; g < NCOPY; g++) begin : g_copy
    bpr_store #(.MIN_BP(g == 0 ? MAIN_MIN : ALIAS_MIN)) u_store (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (copy_wr[g]),
      .wr_val_i(wr_val),
      .val_o   (copy_val[g])
    );
  end

  bpr_view #(.DATA_W(DATA_W), .MAIN_MIN(MAIN_MIN)) u_view (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ns_acc_i   (ns_acc),
    .shared_bp_i(shared_bp_i),
    .main_i     (copy_val[0]),
    .alias_i    (copy_val[1]),
    .rd_data_o  (rd_data_o)
  );

  logic use_alias;
  assign use_alias = SEC_EXT && irq_group1_i && !shared_bp_i;

  bpr_preempt #(.PRIO_W(PRIO_W), .LOW_BP(LOW_BP)) u_preempt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .use_alias_i(use_alias),
    .main_i     (copy_val[0]),
    .alias_i    (copy_val[1]),
    .prio_i     (prio_i),
    .eff_bp_o   (eff_bp_o),
    .grp_prio_o (grp_prio_o)
  );

  AST_NS_SHARED_WR_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !acc_secure_i && shared_bp_i && SEC_EXT)
      |=> ($stable(copy_val[0]) && $stable(copy_val[1]))); // R4
  AST_SEC_WR_ALIAS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && acc_secure_i) |=> $stable(copy_val[1])); // R2
  AST_NS_WR_MAIN_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !acc_secure_i && SEC_EXT) |=> $stable(copy_val[0])); // R3
endmodule

// File: tb/bpr_bank_bench.sv
`timescale 1ns/1ps
module bpr_bank_bench;
  localparam int DW = 32;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          sec = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic          shared = 1'b0;
  logic          g1 = 1'b0;
  logic [PW-1:0] prio = '0;
  logic [DW-1:0] rdata, rdata_f;
  logic [2:0]    eff, eff_f;
  logic [PW-1:0] grp, grp_f;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bpr_bank u_bpr_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .acc_secure_i(sec),
    .wr_data_i(wdata), .rd_data_o(rdata), .shared_bp_i(shared),
    .irq_group1_i(g1), .prio_i(prio), .eff_bp_o(eff), .grp_prio_o(grp)
  );

  bpr_bank #(.SEC_EXT(1'b0)) u_bpr_bank_flat (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .acc_secure_i(sec),
    .wr_data_i(wdata), .rd_data_o(rdata_f), .shared_bp_i(shared),
    .irq_group1_i(g1), .prio_i(prio), .eff_bp_o(eff_f), .grp_prio_o(grp_f)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int maxi(input int a, input int b); return a > b ? a : b; endfunction
  function automatic int mini(input int a, input int b); return a < b ? a : b; endfunction
  function automatic int gmask(input int p, input int bp);
    return p & ((256 - (1 << (bp + 1))) & 255);
  endfunction

  task automatic wr(input logic s, input logic c, input int v);
    @(negedge clk);
    sec = s; shared = c; wdata = DW'(v); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic s, input logic c, output int v, output int vf);
    sec = s; shared = c;
    #0.5;
    v = int'(rdata); vf = int'(rdata_f);
  endtask

  task automatic sweep_prio(input int mv, input int av);
    for (int gg = 0; gg < 2; gg++)
      for (int cc = 0; cc < 2; cc++)
        for (int p = 0; p < 256; p++) begin
          int ebp;
          g1 = gg[0]; shared = cc[0]; prio = PW'(p);
          #0.5;
          ebp = (gg == 1 && cc == 0) ? av - 1 : mv;
          if (p == 0) chk("R7 eff_bp", int'(eff), ebp);
          chk("R8 grp_prio", int'(grp), gmask(p, ebp));
        end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, vf, main_exp, alias_exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(1'b1, 1'b0, v, vf); chk("R1 main reset", v, 2);
    rd(1'b0, 1'b0, v, vf); chk("R1 alias reset", v, 3);
    main_exp = 2; alias_exp = 3;

    // R2, R5: secure writes, shared view
    for (int x = 0; x < 16; x++) begin
      wr(1'b1, 1'b0, x | 32'hFFFF_FFF0 & 32'h0000_00F0);
      main_exp = maxi(x & 7, 2);
      rd(1'b1, 1'b0, v, vf); chk("R2 secure readback", v, main_exp);
      rd(1'b0, 1'b0, v, vf); chk("R2 alias untouched", v, alias_exp);
      rd(1'b0, 1'b1, v, vf); chk("R5 shared view", v, mini(main_exp + 1, 7));
    end

    // R3, R6: non-secure writes, control clear
    for (int x = 0; x < 16; x++) begin
      wr(1'b0, 1'b0, x);
      alias_exp = maxi(x & 7, 3);
      rd(1'b0, 1'b0, v, vf); chk("R6 alias readback", v, alias_exp);
      rd(1'b1, 1'b0, v, vf); chk("R3 main untouched", v, main_exp);
    end

    // R4: non-secure writes with control set are dropped
    wr(1'b1, 1'b0, 4); main_exp = 4;
    wr(1'b0, 1'b0, 5); alias_exp = 5;
    for (int x = 0; x < 8; x++) begin
      wr(1'b0, 1'b1, x);
      rd(1'b1, 1'b0, v, vf); chk("R4 main kept", v, main_exp);
      rd(1'b0, 1'b0, v, vf); chk("R4 alias kept", v, alias_exp);
    end

    // R7, R8: grading over several main/alias pairs
    for (int k = 0; k < 4; k++) begin
      int mv, av;
      mv = (k == 0) ? 2 : (k == 1) ? 7 : (k == 2) ? 3 : 5;
      av = (k == 0) ? 7 : (k == 1) ? 3 : (k == 2) ? 6 : 5;
      wr(1'b1, 1'b0, mv);
      wr(1'b0, 1'b0, av);
      @(negedge clk);
      sweep_prio(mv, av);
    end

    // R9: instance without security feature
    for (int x = 0; x < 16; x++) begin
      wr(x[0], x[1], x);
      rd(1'b0, 1'b1, v, vf); chk("R9 flat ns read", vf, maxi(x & 7, 2));
      rd(1'b1, 1'b0, v, vf); chk("R9 flat s read", vf, maxi(x & 7, 2));
      g1 = 1'b1; shared = 1'b0; prio = 8'hFF; #0.5;
      chk("R9 flat eff_bp", int'(eff_f), maxi(x & 7, 2));
      chk("R9 flat grp_prio", int'(grp_f), gmask(255, maxi(x & 7, 2)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule